// File: doc/BRIEF.md
# Scanline Stream Fetcher with Double Line Buffer

The block copies raw bytes out of one linear frame buffer in memory into a pair of scanline stores. Each horizontal sync strobe starts a burst of N sequential byte reads through a single fetch pointer. Software writes N through a small register port. The bytes go, unaltered, into the pending store. The same strobe also swaps the two stores, so the line fetched during one scanline is the one shown during the next. A pixel pipeline downstream reads the displayed store through a synchronous read port. It is free to interpret the bits in any way, because the fetcher attaches no meaning to them.

Base address and N are staged. They reach the active copy only at a frame start, which is a vertical sync strobe or a software restart command. Between frame starts the pointer moves forward by N on every line. A line that has not finished fetching when the next horizontal strobe arrives does not hold up the swap. Instead it sets a sticky underrun flag. The memory port holds its request and address until it receives an acknowledge, so memories with variable latency work without extra logic.

The fetch state machine has three states:
- **Idle**: no request is outstanding.
- **Fetch**: a request is held for the byte at the current address. Each acknowledge writes the byte and steps the address. The last acknowledge returns the machine to Idle.
- **Drain**: a horizontal strobe arrived while a request was still unacknowledged. The old request is held until it is acknowledged, and its data is discarded. The machine then moves to Fetch for the new line, or to Idle if the new line has N = 0.

The machine moves from Idle to Fetch on a horizontal strobe when N is nonzero. From Fetch, a horizontal strobe leads back to Fetch (new line) or to Idle when the current acknowledge arrives in the same cycle; otherwise it leads to Drain.

Top module: `line_stream_dma`

## Requirements
- R1: After reset `mem_req` and `underrun` are 0.
- R2: A one-cycle `hsync` pulse starts a burst of exactly N acknowledged reads at consecutive byte addresses, beginning at the fetch pointer. Each accepted acknowledge moves `mem_addr` up by one.
- R3: Each fetched byte is stored unaltered at index i of the pending store, where i is its position in the burst. After the next `hsync` pulse it is returned on `disp_data` one cycle after `disp_addr` = i.
- R4: Within a frame, each line starts N bytes after the start of the previous line.
- R5: A write with `cfg_sel`=0 stages the base address and a write with `cfg_sel`=1 stages N. Neither has an effect until a frame start. A frame start is a `vsync` pulse or a write with `cfg_sel`=2. It reloads the pointer from the staged base, and when it coincides with `hsync` that line already uses the new values. A write with `cfg_sel`=3 has no effect.
- R6: A value of N above LINE_MAX (256 by default) is clamped to LINE_MAX.
- R7: With N = 0, `hsync` issues no memory request.
- R8: If `hsync` arrives before the current burst has received its last acknowledge, the stores still swap and `underrun` goes to 1. It stays at 1 until a `cfg_sel`=2 write clears it.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req` and `mem_addr` keep their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 byte count, 2 frame restart, 3 none |
| cfg_wdata | input | ADDR_W | Register write data |
| hsync | input | 1 | One-cycle line start strobe |
| vsync | input | 1 | One-cycle frame start strobe |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | DATA_W | Read data |
| disp_addr | input | IDX_W | Byte index into the displayed store |
| disp_data | output | DATA_W | Displayed store byte, one cycle after `disp_addr` |
| underrun | output | 1 | Sticky late-burst flag |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 8-bit data and 256-byte stores. With these values a single count write of 300 reaches the clamp, and the highest store index, 255, can be read back.

The memory model acknowledges with a latency that the bench can change. A latency of zero gives back-to-back bursts. A latency of three stretches a 40-byte line far enough that a second strobe lands mid-burst, while a request is still unacknowledged, which exercises the Drain state and the underrun flag.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_t;

    localparam logic [1:0] SEL_BASE    = 2'd0;
    localparam logic [1:0] SEL_COUNT   = 2'd1;
    localparam logic [1:0] SEL_RESTART = 2'd2;

endpackage

// File: rtl/lsd_line_ram.sv
module lsd_line_ram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
        rd_data <= store[rd_idx];
    end

endmodule

// File: rtl/lsd_cfg_regs.sv
module lsd_cfg_regs
    import lsd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LINE_MAX = 256,
    parameter int CNT_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              vsync,
    output logic              frame_load,
    output logic              restart_cmd,
    output logic [ADDR_W-1:0] load_base,
    output logic [CNT_W-1:0]  cur_count
);

    logic [ADDR_W-1:0] stg_base_q;
    logic [CNT_W-1:0]  stg_count_q;
    logic [CNT_W-1:0]  act_count_q;
    logic [CNT_W-1:0]  clamped;

    // Clamp the requested byte count to the line store depth.
    always_comb begin
        if (cfg_wdata > ADDR_W'(LINE_MAX)) begin
            clamped = CNT_W'(LINE_MAX);
        end else begin
            clamped = cfg_wdata[CNT_W-1:0];
        end
    end

    assign restart_cmd = cfg_we && (cfg_sel == SEL_RESTART);
    assign frame_load  = vsync || restart_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_base_q  <= '0;
            stg_count_q <= '0;
            act_count_q <= '0;
        end else begin
            if (cfg_we && cfg_sel == SEL_BASE) begin
                stg_base_q <= cfg_wdata;
            end
            if (cfg_we && cfg_sel == SEL_COUNT) begin
                stg_count_q <= clamped;
            end
            if (frame_load) begin
                act_count_q <= stg_count_q;
            end
        end
    end

    assign load_base = stg_base_q;
    assign cur_count = frame_load ? stg_count_q : act_count_q;

    // R5: the active count only changes at a frame start.
    a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> act_count_q == $past(act_count_q));

    // R6: the active count never exceeds the store depth.
    a_r6_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        act_count_q <= CNT_W'(LINE_MAX));

endmodule

// File: rtl/lsd_fetch_fsm.sv
module lsd_fetch_fsm
    import lsd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LINE_MAX = 256,
    parameter int CNT_W    = 9,
    parameter int IDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_go,
    input  logic              frame_load,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              clear_under,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              underrun
);

    fetch_state_t state_q, state_d;

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] next_addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  next_left_q;
    logic [IDX_W-1:0]  idx_q;
    logic              under_q;

    logic [ADDR_W-1:0] line_start;
    logic              last_beat;
    logic              burst_late;
    logic              fresh_burst;

    assign line_start = frame_load ? load_base : ptr_q;
    assign last_beat  = (state_q == FS_FETCH) && mem_ack && (left_q == CNT_W'(1));
    assign burst_late = (state_q != FS_IDLE) && !last_beat;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (line_go && cur_count != '0) begin
                    state_d = FS_FETCH;
                end
            end
            FS_FETCH: begin
                if (line_go) begin
                    if (!mem_ack) begin
                        state_d = FS_DRAIN;
                    end else if (cur_count != '0) begin
                        state_d = FS_FETCH;
                    end else begin
                        state_d = FS_IDLE;
                    end
                end else if (last_beat) begin
                    state_d = FS_IDLE;
                end
            end
            FS_DRAIN: begin
                if (mem_ack) begin
                    if ((line_go ? cur_count : next_left_q) != '0) begin
                        state_d = FS_FETCH;
                    end else begin
                        state_d = FS_IDLE;
                    end
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fresh_burst = (state_d == FS_FETCH) && ((state_q != FS_FETCH) || line_go);

    // Datapath: pointer, burst address, remaining count, store index, flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            addr_q      <= '0;
            next_addr_q <= '0;
            left_q      <= '0;
            next_left_q <= '0;
            idx_q       <= '0;
            under_q     <= 1'b0;
        end else begin
            if (line_go) begin
                ptr_q <= line_start + ADDR_W'(cur_count);
            end else if (frame_load) begin
                ptr_q <= load_base;
            end

            if (line_go && burst_late) begin
                under_q <= 1'b1;
            end else if (clear_under) begin
                under_q <= 1'b0;
            end

            if (line_go && state_q != FS_IDLE && !mem_ack) begin
                next_addr_q <= line_start;
                next_left_q <= cur_count;
            end

            if (fresh_burst) begin
                addr_q <= line_go ? line_start : next_addr_q;
                left_q <= line_go ? cur_count  : next_left_q;
                idx_q  <= '0;
            end else if (state_q == FS_FETCH && mem_ack) begin
                addr_q <= addr_q + ADDR_W'(1);
                left_q <= left_q - CNT_W'(1);
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req  = (state_q != FS_IDLE);
        mem_addr = addr_q;
        wr_en    = (state_q == FS_FETCH) && mem_ack;
        wr_idx   = idx_q;
        underrun = under_q;
    end

    // R9: a pending request is held with its address until acknowledged.
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: consecutive beats of one burst step the address by one.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_FETCH && mem_ack && !line_go && left_q != CNT_W'(1))
        |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R7: a zero-length line leaves the memory port quiet.
    a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (line_go && cur_count == '0 && (state_q == FS_IDLE || mem_ack)) |=> !mem_req);

    // R8: the flag is sticky until cleared.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clear_under) |=> underrun);

    // R8: the flag only rises after a line strobe.
    a_r8_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(line_go));

endmodule

// File: rtl/line_stream_dma.sv
module line_stream_dma
    import lsd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int LINE_MAX = 256,
    localparam int IDX_W   = $clog2(LINE_MAX),
    localparam int CNT_W   = $clog2(LINE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              hsync,
    input  logic              vsync,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  disp_addr,
    output logic [DATA_W-1:0] disp_data,
    output logic              underrun
);

    logic              frame_load;
    logic              restart_cmd;
    logic [ADDR_W-1:0] load_base;
    logic [CNT_W-1:0]  cur_count;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              disp_sel_q;
    logic              rd_sel_q;
    logic [DATA_W-1:0] rd_bank [2];

    lsd_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .LINE_MAX (LINE_MAX),
        .CNT_W    (CNT_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .vsync       (vsync),
        .frame_load  (frame_load),
        .restart_cmd (restart_cmd),
        .load_base   (load_base),
        .cur_count   (cur_count)
    );

    lsd_fetch_fsm #(
        .ADDR_W   (ADDR_W),
        .LINE_MAX (LINE_MAX),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_go     (hsync),
        .frame_load  (frame_load),
        .load_base   (load_base),
        .cur_count   (cur_count),
        .clear_under (restart_cmd),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .underrun    (underrun)
    );

    // Role swap: bank disp_sel_q is shown, the other one is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_sel_q <= 1'b0;
            rd_sel_q   <= 1'b0;
        end else begin
            if (hsync) begin
                disp_sel_q <= ~disp_sel_q;
            end
            rd_sel_q <= disp_sel_q;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        lsd_line_ram #(
            .DEPTH  (LINE_MAX),
            .DATA_W (DATA_W)
        ) i_ram (
            .clk     (clk),
            .wr_en   (wr_en && (disp_sel_q != 1'(g))),
            .wr_idx  (wr_idx),
            .wr_data (mem_rdata),
            .rd_idx  (disp_addr),
            .rd_data (rd_bank[g])
        );
    end

    assign disp_data = rd_bank[rd_sel_q];

    // R3: every line strobe exchanges the roles of the two stores.
    a_r3_swap_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> disp_sel_q != $past(disp_sel_q));

endmodule

// File: tb/test_line_stream_dma.sv
module test_line_stream_dma;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 8;
    localparam int LM = 256;
    localparam int IW = $clog2(LM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [IW-1:0] disp_addr = '0;
    logic [DW-1:0] disp_data;
    logic          underrun;

    int n_chk = 0;
    int n_err = 0;
    int lat = 0;
    int n_acks = 0;
    bit chk_addr = 1'b1;
    bit done = 1'b0;
    logic [AW-1:0] exp_addr_q [$];
    logic [DW-1:0] exp_byte_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_stream_dma #(.ADDR_W(AW), .DATA_W(DW), .LINE_MAX(LM)) i_line_stream_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .disp_addr(disp_addr), .disp_data(disp_data),
        .underrun(underrun)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Memory responder and address scoreboard monitor
    initial begin
        int waitc;
        logic [AW-1:0] held;
        waitc = 0;
        held = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (waitc == 0) held = mem_addr;
                else chk("R9 address held while waiting", mem_addr, held);
                if (waitc >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = pat(mem_addr);
                    n_acks++;
                    if (chk_addr) begin
                        if (exp_addr_q.size() == 0) begin
                            chk("R2 unexpected request", mem_addr, 32'hFFFFFFFF);
                        end else begin
                            chk("R2/R4 request address", mem_addr, exp_addr_q.pop_front());
                        end
                    end
                    waitc = 0;
                end else begin
                    waitc++;
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic line_pulse(input bit with_frame);
        @(negedge clk);
        hsync = 1'b1; vsync = with_frame;
        @(negedge clk);
        hsync = 1'b0; vsync = 1'b0;
    endtask

    task automatic push_line(input logic [AW-1:0] start, input int n);
        for (int i = 0; i < n; i++) exp_addr_q.push_back(start + AW'(i));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!mem_req && !mem_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic end_line(input string tag, input int n);
        chk({tag, " burst length"}, n_acks, n);
        chk({tag, " all addresses seen"}, exp_addr_q.size(), 0);
        n_acks = 0;
    endtask

    // Reads the displayed store and compares against the byte scoreboard
    task automatic read_disp(input string tag, input int idx);
        @(negedge clk);
        disp_addr = IW'(idx);
        @(negedge clk);
        chk(tag, disp_data, exp_byte_q.pop_front());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req after reset", mem_req, 0);
        chk("R1 underrun after reset", underrun, 0);

        // R2/R3/R4: two lines of 16 bytes from 0x1000
        cfg_write(2'd0, 24'h001000);
        cfg_write(2'd1, 24'd16);
        cfg_write(2'd2, 24'd0);
        n_acks = 0;
        push_line(24'h001000, 16);
        line_pulse(1'b0);
        wait_idle();
        end_line("R2 line0", 16);
        lat = 2;
        push_line(24'h001010, 16);
        line_pulse(1'b0);
        for (int i = 0; i < 16; i++) exp_byte_q.push_back(pat(24'h001000 + AW'(i)));
        for (int i = 0; i < 16; i++) read_disp("R3 displayed line0 byte", i);
        wait_idle();
        end_line("R4 line1", 16);

        // R5: staged writes mid-frame do not act yet
        cfg_write(2'd0, 24'h002000);
        cfg_write(2'd1, 24'd4);
        cfg_write(2'd3, 24'h00FFFF);
        lat = 1;
        push_line(24'h001020, 16);
        line_pulse(1'b0);
        for (int i = 0; i < 16; i++) exp_byte_q.push_back(pat(24'h001010 + AW'(i)));
        for (int i = 0; i < 16; i++) read_disp("R3 displayed line1 byte", i);
        wait_idle();
        end_line("R5 staged values not yet active", 16);

        // R5: frame start coinciding with a line uses the new values
        push_line(24'h002000, 4);
        line_pulse(1'b1);
        wait_idle();
        end_line("R5 frame start reload", 4);
        push_line(24'h002004, 4);
        line_pulse(1'b0);
        wait_idle();
        end_line("R4 advance by new count", 4);

        // R6: oversize count clamps to LM
        lat = 0;
        cfg_write(2'd0, 24'h003000);
        cfg_write(2'd1, 24'd300);
        cfg_write(2'd2, 24'd0);
        push_line(24'h003000, LM);
        line_pulse(1'b0);
        wait_idle();
        end_line("R6 clamped burst", LM);
        push_line(24'h003000 + AW'(LM), LM);
        line_pulse(1'b0);
        exp_byte_q.push_back(pat(24'h003000 + AW'(LM - 1)));
        read_disp("R6 last store byte", LM - 1);
        exp_byte_q.push_back(pat(24'h003000));
        read_disp("R3 first store byte", 0);
        wait_idle();
        end_line("R6 clamped burst 2", LM);

        // R7: zero count issues nothing
        cfg_write(2'd1, 24'd0);
        cfg_write(2'd2, 24'd0);
        line_pulse(1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R7 no request for zero count", mem_req, 0);
        end
        end_line("R7 zero burst", 0);

        // R8: late burst sets sticky underrun
        chk_addr = 1'b0;
        lat = 3;
        cfg_write(2'd0, 24'h004000);
        cfg_write(2'd1, 24'd40);
        cfg_write(2'd2, 24'd0);
        chk("R8 clear before overrun", underrun, 0);
        line_pulse(1'b0);
        repeat (12) @(negedge clk);
        chk("R8 clear during burst", underrun, 0);
        line_pulse(1'b0);
        chk("R8 set by late line", underrun, 1);
        wait_idle();
        chk("R8 sticky after drain", underrun, 1);
        cfg_write(2'd3, 24'd0);
        chk("R5 select 3 leaves flag", underrun, 1);
        cfg_write(2'd2, 24'd0);
        chk("R8 cleared by restart", underrun, 0);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule